// File: doc/BRIEF.md
# Dual Wiper Step and Shift Unit

This block holds two wiper position codes, 10 bits each by default, and changes them when commands arrive from an upstream frame decoder. A command can load a new code directly, step a code up or down by one with saturation, rotate it right to roughly halve it, or shift it left to roughly double it. Each adjustment goes either to the one channel chosen by the address or to both channels together.

The unit keeps a copy of the last step or shift command. A bare chip-select strobe, one that arrives with no new command, runs that copy again. This lets a push-button drive the wiper without the host sending new frames. Any other kind of command clears the copy. Frame capture and non-volatile storage are handled outside this block. The wiper codes go straight to the resistor decoders.

Top module: `wiper_adjust_unit`

## Requirements
- R1: After reset both wiper outputs equal RESET_CODE, which defaults to 512 (midscale).
- R2: Command code 11 (4'b1011) writes cmd_data into wiper 0 when cmd_addr is 0 and into wiper 1 when cmd_addr is 1.
- R3: Code 14 adds one to the addressed wiper and code 15 adds one to both wipers. A wiper that is already at all ones (1023) keeps that value.
- R4: Code 6 subtracts one from the addressed wiper and code 7 subtracts one from both wipers. A wiper that is already at zero keeps that value.
- R5: Code 4 rotates the addressed wiper right by one place and code 5 does the same to both wipers. The old bit 0 becomes the new most significant bit.
- R6: Code 12 shifts the addressed wiper left by one place and code 13 does the same to both wipers. A 1 enters at bit 0. If the most significant bit was already set, the result is all ones.
- R7: Step and shift commands (codes 4, 5, 6, 7, 12, 13, 14, 15) ignore cmd_data.
- R8: A step or shift command becomes the stored repeat command, together with its address. A cs_strobe pulse without cmd_valid then runs the stored command once more.
- R9: Any command with a code other than 4, 5, 6, 7, 12, 13, 14 or 15 (the load code 11 included) clears the stored repeat command. Bare strobes that follow change nothing.
- R10: A single-channel command (load, step or shift) whose address is neither 0 nor 1 leaves both wipers unchanged.
- R11: If cmd_valid and cs_strobe are both high in the same cycle, only the new command runs, and it runs once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present in this cycle |
| cmd_code | input | 4 | Command code |
| cmd_addr | input | 4 | Channel address |
| cmd_data | input | 10 | Code for the load command |
| cs_strobe | input | 1 | Chip-select strobe with no new frame (repeat request) |
| wiper0 | output | 10 | Wiper code of channel 0 |
| wiper1 | output | 10 | Wiper code of channel 1 |

## Verification
The assertions assume that each command or strobe lasts exactly one clock cycle. They also assume that cmd_valid and cs_strobe are driven only by the clock domain of the block, so the stored repeat command changes only when a command is accepted. The stimulus changes inputs only on the falling clock edge and drops cmd_valid and cs_strobe after a single cycle. The sequence includes the cases where both strobes are high together and where the address is out of range. A behavioural model in the bench is compared against both wipers on every cycle.

// File: rtl/wadj_pkg.sv
package wadj_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [2:0] {
    OP_NONE, OP_LOAD, OP_INC, OP_DEC, OP_ROR, OP_SHL
  } op_e;

  typedef struct packed {
    op_e  op;
    logic all_ch;
    logic repeatable;
  } dec_t;

  function automatic dec_t decode(input logic [CMD_W-1:0] c);
    dec_t d;
    d = '{op: OP_NONE, all_ch: 1'b0, repeatable: 1'b0};
    case (c)
      4'd4:  d = '{op: OP_ROR,  all_ch: 1'b0, repeatable: 1'b1};
      4'd5:  d = '{op: OP_ROR,  all_ch: 1'b1, repeatable: 1'b1};
      4'd6:  d = '{op: OP_DEC,  all_ch: 1'b0, repeatable: 1'b1};
      4'd7:  d = '{op: OP_DEC,  all_ch: 1'b1, repeatable: 1'b1};
      4'd11: d = '{op: OP_LOAD, all_ch: 1'b0, repeatable: 1'b0};
      4'd12: d = '{op: OP_SHL,  all_ch: 1'b0, repeatable: 1'b1};
      4'd13: d = '{op: OP_SHL,  all_ch: 1'b1, repeatable: 1'b1};
      4'd14: d = '{op: OP_INC,  all_ch: 1'b0, repeatable: 1'b1};
      4'd15: d = '{op: OP_INC,  all_ch: 1'b1, repeatable: 1'b1};
      default: d = '{op: OP_NONE, all_ch: 1'b0, repeatable: 1'b0};
    endcase
    return d;
  endfunction
endpackage

// File: rtl/wadj_repeat.sv
module wadj_repeat #(
  parameter int CMD_W  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_repeatable,
  input  logic              cs_strobe,
  output logic              act_valid,
  output logic [CMD_W-1:0]  act_code,
  output logic [ADDR_W-1:0] act_addr
);
  logic              rep_valid_q, rep_valid_d;
  logic [CMD_W-1:0]  rep_code_q, rep_code_d;
  logic [ADDR_W-1:0] rep_addr_q, rep_addr_d;
  logic              rep_en;

  // a new command always wins over a bare strobe
  always_comb begin
    act_valid = 1'b0;
    act_code  = cmd_code;
    act_addr  = cmd_addr;
    if (cmd_valid) begin
      act_valid = 1'b1;
    end else if (cs_strobe && rep_valid_q) begin
      act_valid = 1'b1;
      act_code  = rep_code_q;
      act_addr  = rep_addr_q;
    end
  end

  always_comb begin
    rep_en      = cmd_valid;
    rep_valid_d = cmd_repeatable;
    rep_code_d  = cmd_code;
    rep_addr_d  = cmd_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_valid_q <= 1'b0;
      rep_code_q  <= '0;
      rep_addr_q  <= '0;
    end else if (rep_en) begin
      rep_valid_q <= rep_valid_d;
      rep_code_q  <= rep_code_d;
      rep_addr_q  <= rep_addr_d;
    end
  end

  // R9
  rep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_repeatable) |=> !rep_valid_q);

  // R8
  rep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(rep_valid_q) && $stable(rep_code_q) && $stable(rep_addr_q)));
endmodule

// File: rtl/wadj_lane.sv
module wadj_lane
  import wadj_pkg::*;
#(
  parameter int              CODE_W     = 10,
  parameter int              ADDR_W     = 4,
  parameter int              CH_IDX     = 0,
  parameter logic [CODE_W-1:0] RESET_CODE = 10'd512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_valid,
  input  op_e               act_op,
  input  logic              act_all,
  input  logic [ADDR_W-1:0] act_addr,
  input  logic [CODE_W-1:0] act_data,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] ONE  = CODE_W'(1);

  logic [CODE_W-1:0] code_q, code_d;
  logic              hit, en;

  always_comb begin
    hit = act_all || (act_addr == ADDR_W'(CH_IDX));
    en  = act_valid && (act_op != OP_NONE) && hit;
  end

  always_comb begin
    code_d = code_q;
    case (act_op)
      OP_LOAD: code_d = act_data;
      OP_INC:  code_d = (code_q == FULL) ? FULL : code_q + ONE;
      OP_DEC:  code_d = (code_q == '0) ? '0 : code_q - ONE;
      OP_ROR:  code_d = {code_q[0], code_q[CODE_W-1:1]};
      OP_SHL:  code_d = code_q[CODE_W-1] ? FULL : {code_q[CODE_W-2:0], 1'b1};
      default: code_d = code_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= RESET_CODE;
    else if (en) code_q <= code_d;
  end

  assign code = code_q;

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(code_q));

  // R3
  inc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_op == OP_INC && code_q == FULL) |=> code_q == FULL);

  // R4
  dec_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_op == OP_DEC && code_q == '0) |=> code_q == '0);

  // R5
  ror_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_op == OP_ROR) |=> code_q[CODE_W-1] == $past(code_q[0]));

  // R6
  shl_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_op == OP_SHL && code_q[CODE_W-1]) |=> code_q == FULL);
endmodule

// File: rtl/wiper_adjust_unit.sv
module wiper_adjust_unit
  import wadj_pkg::*;
#(
  parameter int                CODE_W     = 10,
  parameter int                ADDR_W     = 4,
  parameter logic [CODE_W-1:0] RESET_CODE = 10'd512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CODE_W-1:0] cmd_data,
  input  logic              cs_strobe,
  output logic [CODE_W-1:0] wiper0,
  output logic [CODE_W-1:0] wiper1
);
  localparam int NUM_CH = 2;

  logic              act_valid;
  logic [CMD_W-1:0]  act_code;
  logic [ADDR_W-1:0] act_addr;
  dec_t              new_dec, act_dec;
  logic [CODE_W-1:0] lane_code [NUM_CH];

  always_comb begin
    new_dec = decode(cmd_code);
    act_dec = decode(act_code);
  end

  wadj_repeat #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_repeat (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_code       (cmd_code),
    .cmd_addr       (cmd_addr),
    .cmd_repeatable (new_dec.repeatable),
    .cs_strobe      (cs_strobe),
    .act_valid      (act_valid),
    .act_code       (act_code),
    .act_addr       (act_addr)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    wadj_lane #(
      .CODE_W(CODE_W), .ADDR_W(ADDR_W), .CH_IDX(ch), .RESET_CODE(RESET_CODE)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_valid (act_valid),
      .act_op    (act_dec.op),
      .act_all   (act_dec.all_ch),
      .act_addr  (act_addr),
      .act_data  (cmd_data),
      .code      (lane_code[ch])
    );
  end

  assign wiper0 = lane_code[0];
  assign wiper1 = lane_code[1];

  // R11
  dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cs_strobe) |-> (act_code == cmd_code && act_addr == cmd_addr));
endmodule

// File: tb/wiper_adjust_unit_bench.sv
module wiper_adjust_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_code = '0;
  logic [3:0] cmd_addr = '0;
  logic [9:0] cmd_data = '0;
  logic       cs_strobe = 1'b0;
  logic [9:0] wiper0, wiper1;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  wiper_adjust_unit u_wiper_adjust_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cs_strobe(cs_strobe),
    .wiper0(wiper0), .wiper1(wiper1)
  );

  // behavioural reference
  int m_w [2];
  bit m_rep;
  int m_code, m_addr;

  function automatic int step(int v, int code);
    case (code)
      4, 5:   return (v / 2) + ((v % 2) * 512);
      6, 7:   return (v == 0) ? 0 : v - 1;
      12, 13: return (v >= 512) ? 1023 : v * 2 + 1;
      14, 15: return (v == 1023) ? 1023 : v + 1;
      default: return v;
    endcase
  endfunction

  function automatic bit is_adj(int code);
    return code inside {4, 5, 6, 7, 12, 13, 14, 15};
  endfunction

  task automatic model_apply(int code, int addr, int data);
    if (code == 11) begin
      if (addr < 2) m_w[addr] = data;
    end else if (is_adj(code)) begin
      if (code inside {5, 7, 13, 15}) begin
        m_w[0] = step(m_w[0], code);
        m_w[1] = step(m_w[1], code);
      end else if (addr < 2) begin
        m_w[addr] = step(m_w[addr], code);
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_w[0] = 512; m_w[1] = 512; m_rep = 1'b0; m_code = 0; m_addr = 0;
    end else begin
      cycles++;
      if (cmd_valid) begin
        model_apply(int'(cmd_code), int'(cmd_addr), int'(cmd_data));
        m_rep  = is_adj(int'(cmd_code));
        m_code = int'(cmd_code);
        m_addr = int'(cmd_addr);
      end else if (cs_strobe && m_rep) begin
        model_apply(m_code, m_addr, 0);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (int'(wiper0) != m_w[0] || int'(wiper1) != m_w[1]) begin
        n_fail++;
        $display("FAIL R2 R3 R4 R5 R6 model: got %0d/%0d exp %0d/%0d",
                 wiper0, wiper1, m_w[0], m_w[1]);
      end
    end
  end

  task automatic chk(string req, int e0, int e1);
    n_tests++;
    if (int'(wiper0) != e0 || int'(wiper1) != e1) begin
      n_fail++;
      $display("FAIL %s: got %0d/%0d exp %0d/%0d", req, wiper0, wiper1, e0, e1);
    end
  endtask

  task automatic cmd(int code, int addr, int data, bit cs = 1'b0);
    cmd_valid = 1'b1; cmd_code = 4'(code); cmd_addr = 4'(addr);
    cmd_data = 10'(data); cs_strobe = cs;
    @(negedge clk);
    cmd_valid = 1'b0; cs_strobe = 1'b0;
  endtask

  task automatic strobe();
    cs_strobe = 1'b1;
    @(negedge clk);
    cs_strobe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", 512, 512);
    cmd(11, 0, 5);            chk("R2 load w0", 5, 512);
    cmd(11, 1, 1020);         chk("R2 load w1", 5, 1020);
    cmd(15, 0, 0);            chk("R3 inc all", 6, 1021);
    strobe(); strobe(); strobe();
    chk("R3 R8 inc repeat saturate", 9, 1023);
    cmd(6, 0, 1023);          chk("R4 R7 dec w0 data ignored", 8, 1023);
    strobe();                 chk("R8 repeat keeps address", 7, 1023);
    cmd(11, 0, 1);
    cmd(7, 0, 0);             chk("R4 dec all", 0, 1022);
    strobe();                 chk("R4 floor at zero", 0, 1021);
    cmd(4, 1, 0);             chk("R5 rotate w1 odd", 0, 1022);
    strobe();                 chk("R5 rotate w1 even", 0, 511);
    cmd(5, 0, 0);             chk("R5 rotate all", 0, 767);
    cmd(12, 0, 0);            chk("R6 shl w0", 1, 767);
    strobe(); strobe();       chk("R6 shl repeat", 7, 767);
    cmd(13, 0, 0);            chk("R6 shl all saturate", 15, 1023);
    cmd(9, 0, 0);
    strobe();                 chk("R9 repeat cleared", 15, 1023);
    cmd(11, 0, 15);
    strobe();                 chk("R9 load clears repeat", 15, 1023);
    cmd(14, 2, 0);            chk("R10 bad address inc", 15, 1023);
    strobe();                 chk("R10 bad address repeat", 15, 1023);
    cmd(11, 3, 7);            chk("R10 bad address load", 15, 1023);
    cmd(14, 0, 0);            chk("R3 inc w0", 16, 1023);
    cmd(6, 0, 0, 1'b1);       chk("R11 both strobes", 15, 1023);
    strobe();                 chk("R11 repeat is new command", 14, 1023);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule